// File: doc/BRIEF.md
# ARP Request Responder

This block sits behind an Ethernet frame receiver that has already pulled the address-resolution fields out of an incoming frame. Each parsed message arrives as a one-cycle strobe carrying the operation code, the sender's hardware and protocol addresses, and the protocol address being asked about. The block sorts messages into requests and replies by operation code. It answers only a request whose target protocol address equals the configured local IPv4 address.

When a request is accepted, the requester's MAC and IP are latched. On the next cycle the block starts a complete reply frame, one byte per cycle, towards the transmit MAC. The frame carries the Ethernet header, the ARP reply body built from the configured local MAC and IP, and zero padding up to 60 bytes. The frame check sequence is left to the stage downstream. A received reply is marked with a one-cycle pulse and produces no transmission. While a frame is being sent, the block reports itself busy and discards any new request.

Top module: `arp_responder`

## Requirements
- R1: While reset is held and until the first accepted request, tx_valid, tx_sof, tx_eof, busy and rsp_seen are low, and peer_mac and peer_ip are zero.
- R2: A strobe with operation code 1 and arp_tpa equal to cfg_ip, sampled while busy is low, starts a frame on the following cycle. The frame is exactly 60 consecutive cycles with tx_valid high, with tx_sof on the first byte and tx_eof on the last byte.
- R3: Frame bytes 0-5 are the requester MAC and bytes 6-11 are cfg_mac. Bytes 12-13 are 0x08 0x06. Every multi-byte field is sent most significant byte first.
- R4: Frame bytes 14-21 are 0x00 0x01 0x08 0x00 0x06 0x04 0x00 0x02.
- R5: Frame bytes 22-27 are cfg_mac, 28-31 are cfg_ip, 32-37 are the requester MAC and 38-41 are the requester IP.
- R6: Frame bytes 42-59 are zero.
- R7: From the cycle after an accepted request, peer_mac and peer_ip show that request's arp_sha and arp_spa. They keep those values until the next accepted request.
- R8: A request whose arp_tpa differs from cfg_ip starts no frame and leaves peer_mac and peer_ip unchanged.
- R9: A strobe with operation code 2 raises rsp_seen for exactly the next cycle, whether or not a frame is in progress, and starts no frame. Any code other than 1 or 2 has no effect.
- R10: busy equals tx_valid for the whole frame. A request sampled while busy is high, including during the last byte, is dropped: no extra frame is sent and the peer outputs do not change.
- R11: A matching request sampled on the first cycle after the last byte is accepted, and its frame starts on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block synchronises its release |
| cfg_mac | input | 48 | Local MAC address |
| cfg_ip | input | 32 | Local IPv4 address |
| arp_valid | input | 1 | One-cycle strobe: the parsed fields below are valid |
| arp_opcode | input | 16 | ARP operation code (1 request, 2 reply) |
| arp_sha | input | 48 | Sender hardware address |
| arp_spa | input | 32 | Sender protocol address |
| arp_tpa | input | 32 | Target protocol address |
| tx_valid | output | 1 | Transmit byte valid |
| tx_data | output | 8 | Transmit byte |
| tx_sof | output | 1 | First byte of the frame |
| tx_eof | output | 1 | Last byte of the frame |
| busy | output | 1 | Reply frame in progress |
| peer_mac | output | 48 | MAC of the last accepted requester |
| peer_ip | output | 32 | IP of the last accepted requester |
| rsp_seen | output | 1 | Pulse: an ARP reply was received |

## Verification
The bench drives these stimuli:
- a matching request;
- a request for a foreign address;
- a received reply;
- an unknown operation code;
- a request during a frame;
- a request on the final byte;
- a request on the first idle cycle;
- a reply during a frame;
- a request after the local MAC and IP change.

A reference model predicts every output byte on every cycle. It separates the header, body and pad regions from one another, and it separates live configuration from stale requester data. The three busy-boundary cases show whether a busy decision is off by one cycle. The foreign-address and unknown-code cases show whether the filter wrongly starts a frame or wrongly overwrites the peer record.

// File: rtl/arp_resp_pkg.sv
package arp_resp_pkg;
  localparam int unsigned OCTET        = 8;
  localparam logic [15:0] ETYPE_ARP    = 16'h0806;
  localparam logic [15:0] HW_ETHERNET  = 16'h0001;
  localparam logic [15:0] PROTO_IPV4   = 16'h0800;
  localparam logic [15:0] OPC_REQUEST  = 16'd1;
  localparam logic [15:0] OPC_ANSWER   = 16'd2;
  localparam int unsigned FIXED_BYTES  = 10;  // ethertype + htype + ptype + hlen + plen + opcode

  typedef struct packed {
    logic start;
    logic answer_seen;
  } filt_out_t;
endpackage

// File: rtl/arp_rx_filter.sv
module arp_rx_filter
  import arp_resp_pkg::*;
#(
  parameter int unsigned IP_W = 32
) (
  input  logic            in_valid,
  input  logic [15:0]     in_opcode,
  input  logic [IP_W-1:0] in_tpa,
  input  logic [IP_W-1:0] local_ip,
  input  logic            tx_busy,
  output filt_out_t       decision
);
  logic is_request;
  logic is_answer;
  logic ip_match;

  always_comb begin
    is_request           = (in_opcode == OPC_REQUEST);
    is_answer            = (in_opcode == OPC_ANSWER);
    ip_match             = (in_tpa == local_ip);
    decision.start       = in_valid && is_request && ip_match && !tx_busy;
    decision.answer_seen = in_valid && is_answer;
  end
endmodule

// File: rtl/arp_peer_store.sv
module arp_peer_store #(
  parameter int unsigned MAC_W = 48,
  parameter int unsigned IP_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic [MAC_W-1:0] src_mac,
  input  logic [IP_W-1:0]  src_ip,
  output logic [MAC_W-1:0] held_mac,
  output logic [IP_W-1:0]  held_ip
);
  logic [MAC_W-1:0] mac_d;
  logic [IP_W-1:0]  ip_d;

  always_comb begin
    mac_d = held_mac;
    ip_d  = held_ip;
    if (capture) begin
      mac_d = src_mac;
      ip_d  = src_ip;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_mac <= '0;
      held_ip  <= '0;
    end else begin
      held_mac <= mac_d;
      held_ip  <= ip_d;
    end
  end
endmodule

// File: rtl/arp_frame_seq.sv
module arp_frame_seq #(
  parameter int unsigned FRAME_LEN = 60,
  localparam int unsigned IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             first,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic             active_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    active_d = active;
    idx_d    = idx;
    if (active) begin
      if (idx == LAST_IDX) begin
        active_d = 1'b0;
        idx_d    = '0;
      end else begin
        idx_d = idx + 1'b1;
      end
    end else if (start) begin
      active_d = 1'b1;
      idx_d    = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
    end else begin
      active <= active_d;
      idx    <= idx_d;
    end
  end

  always_comb begin
    first = active && (idx == '0);
    last  = active && (idx == LAST_IDX);
  end

  AST_EOF_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !active);  // R2
  AST_SOF_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> first);  // R2
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);  // R10
endmodule

// File: rtl/arp_byte_mux.sv
module arp_byte_mux
  import arp_resp_pkg::*;
#(
  parameter int unsigned MAC_W     = 48,
  parameter int unsigned IP_W      = 32,
  parameter int unsigned FRAME_LEN = 60,
  localparam int unsigned IDX_W    = $clog2(FRAME_LEN),
  localparam int unsigned MAC_B    = MAC_W / OCTET,
  localparam int unsigned IP_B     = IP_W / OCTET,
  localparam int unsigned HDR_B    = 4 * MAC_B + 2 * IP_B + FIXED_BYTES,
  localparam int unsigned HDR_BITS = HDR_B * OCTET
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [MAC_W-1:0]  local_mac,
  input  logic [IP_W-1:0]   local_ip,
  input  logic [MAC_W-1:0]  peer_mac,
  input  logic [IP_W-1:0]   peer_ip,
  output logic [OCTET-1:0]  byte_out,
  output logic              in_pad
);
  logic [HDR_BITS-1:0] hdr_vec;
  logic [HDR_BITS-1:0] hdr_shift;

  always_comb begin
    hdr_vec = {peer_mac, local_mac, ETYPE_ARP, HW_ETHERNET, PROTO_IPV4,
               8'(MAC_B), 8'(IP_B), OPC_ANSWER,
               local_mac, local_ip, peer_mac, peer_ip};
    hdr_shift = hdr_vec << {idx, 3'b000};
    in_pad    = (int'(idx) >= HDR_B);
    byte_out  = in_pad ? '0 : hdr_shift[HDR_BITS-1 -: OCTET];
  end
endmodule

// File: rtl/arp_responder.sv
module arp_responder
  import arp_resp_pkg::*;
#(
  parameter int unsigned MAC_W     = 48,
  parameter int unsigned IP_W      = 32,
  parameter int unsigned FRAME_LEN = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAC_W-1:0] cfg_mac,
  input  logic [IP_W-1:0]  cfg_ip,
  input  logic             arp_valid,
  input  logic [15:0]      arp_opcode,
  input  logic [MAC_W-1:0] arp_sha,
  input  logic [IP_W-1:0]  arp_spa,
  input  logic [IP_W-1:0]  arp_tpa,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             tx_sof,
  output logic             tx_eof,
  output logic             busy,
  output logic [MAC_W-1:0] peer_mac,
  output logic [IP_W-1:0]  peer_ip,
  output logic             rsp_seen
);
  localparam int unsigned IDX_W = $clog2(FRAME_LEN);

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  filt_out_t        decision;
  logic             seq_active;
  logic [IDX_W-1:0] seq_idx;
  logic             seq_first;
  logic             seq_last;
  logic             pad_zone;
  logic             rsp_seen_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  arp_rx_filter #(.IP_W(IP_W)) u_filter (
    .in_valid  (arp_valid),
    .in_opcode (arp_opcode),
    .in_tpa    (arp_tpa),
    .local_ip  (cfg_ip),
    .tx_busy   (seq_active),
    .decision  (decision)
  );

  arp_peer_store #(.MAC_W(MAC_W), .IP_W(IP_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .capture  (decision.start),
    .src_mac  (arp_sha),
    .src_ip   (arp_spa),
    .held_mac (peer_mac),
    .held_ip  (peer_ip)
  );

  arp_frame_seq #(.FRAME_LEN(FRAME_LEN)) u_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .start  (decision.start),
    .active (seq_active),
    .idx    (seq_idx),
    .first  (seq_first),
    .last   (seq_last)
  );

  arp_byte_mux #(.MAC_W(MAC_W), .IP_W(IP_W), .FRAME_LEN(FRAME_LEN)) u_mux (
    .idx       (seq_idx),
    .local_mac (cfg_mac),
    .local_ip  (cfg_ip),
    .peer_mac  (peer_mac),
    .peer_ip   (peer_ip),
    .byte_out  (tx_data),
    .in_pad    (pad_zone)
  );

  always_comb rsp_seen_d = decision.answer_seen;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rsp_seen <= 1'b0;
    else            rsp_seen <= rsp_seen_d;
  end

  assign tx_valid = seq_active;
  assign busy     = seq_active;
  assign tx_sof   = seq_first;
  assign tx_eof   = seq_last;

  AST_ANSWER_NO_TX: assert property (@(posedge clk) disable iff (!rst_int_n)
    (arp_valid && arp_opcode == OPC_ANSWER) |=> !tx_sof);  // R9
  AST_FOREIGN_NO_TX: assert property (@(posedge clk) disable iff (!rst_int_n)
    (arp_valid && arp_tpa != cfg_ip && !busy) |=> !tx_sof);  // R8
  AST_PEER_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && !tx_sof) |-> ($stable(peer_mac) && $stable(peer_ip)));  // R10
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_valid && pad_zone) |-> (tx_data == 8'h00));  // R6
  AST_SEEN_PULSE: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_seen |-> $past(arp_valid && arp_opcode == OPC_ANSWER));  // R9
endmodule

// File: tb/arp_responder_bench.sv
`timescale 1ns/100ps
module arp_responder_bench;
  localparam int FLEN = 60;

  logic        clk;
  logic        rst_n;
  logic [47:0] cfg_mac;
  logic [31:0] cfg_ip;
  logic        arp_valid;
  logic [15:0] arp_opcode;
  logic [47:0] arp_sha;
  logic [31:0] arp_spa;
  logic [31:0] arp_tpa;
  logic        tx_valid, tx_sof, tx_eof, busy, rsp_seen;
  logic [7:0]  tx_data;
  logic [47:0] peer_mac;
  logic [31:0] peer_ip;

  int total = 0;
  int bad   = 0;
  int sof_count = 0;
  bit finished = 0;

  arp_responder u_arp_responder (
    .clk(clk), .rst_n(rst_n), .cfg_mac(cfg_mac), .cfg_ip(cfg_ip),
    .arp_valid(arp_valid), .arp_opcode(arp_opcode), .arp_sha(arp_sha),
    .arp_spa(arp_spa), .arp_tpa(arp_tpa), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .busy(busy),
    .peer_mac(peer_mac), .peer_ip(peer_ip), .rsp_seen(rsp_seen)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model state
  logic [7:0]  exp_q[$];
  bit          m_busy;
  logic [47:0] m_mac;
  logic [31:0] m_ip;
  bit          m_rs;

  task automatic push_field(input logic [63:0] v, input int nbytes);
    for (int i = nbytes - 1; i >= 0; i--) exp_q.push_back(v[8*i +: 8]);
  endtask

  task automatic build_frame(input logic [47:0] pm, input logic [31:0] pi);
    exp_q.delete();
    push_field(64'(pm), 6);
    push_field(64'(cfg_mac), 6);
    push_field(64'h0806, 2);
    push_field(64'h0001_0800_0604_0002, 8);
    push_field(64'(cfg_mac), 6);
    push_field(64'(cfg_ip), 4);
    push_field(64'(pm), 6);
    push_field(64'(pi), 4);
    while (exp_q.size() < FLEN) exp_q.push_back(8'h00);
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q.delete();
      m_busy = 0; m_mac = '0; m_ip = '0; m_rs = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (m_busy) begin
        void'(exp_q.pop_front());
        if (exp_q.size() == 0) m_busy = 0;
      end
      m_rs = arp_valid && (arp_opcode == 16'd2);
      if (arp_valid && arp_opcode == 16'd1 && arp_tpa == cfg_ip && !was_busy) begin
        m_mac = arp_sha;
        m_ip  = arp_spa;
        build_frame(arp_sha, arp_spa);
        m_busy = 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string data_tag(input int pos);
    if (pos < 14) return "R3 header byte";
    if (pos < 22) return "R4 fixed field";
    if (pos < 42) return "R5 address field";
    return "R6 pad byte";
  endfunction

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int pos;
      pos = FLEN - exp_q.size();
      check(tx_valid == m_busy, "R2 tx_valid", 64'(tx_valid), 64'(m_busy));
      check(busy == m_busy, "R10 busy", 64'(busy), 64'(m_busy));
      check(rsp_seen == m_rs, "R9 rsp_seen", 64'(rsp_seen), 64'(m_rs));
      check(peer_mac == m_mac, "R7 peer_mac", 64'(peer_mac), 64'(m_mac));
      check(peer_ip == m_ip, "R7 peer_ip", 64'(peer_ip), 64'(m_ip));
      if (m_busy) begin
        check(tx_data == exp_q[0], data_tag(pos), 64'(tx_data), 64'(exp_q[0]));
        check(tx_sof == (pos == 0), "R2 tx_sof", 64'(tx_sof), 64'(pos == 0));
        check(tx_eof == (pos == FLEN - 1), "R2 tx_eof", 64'(tx_eof), 64'(pos == FLEN - 1));
      end else begin
        check(!tx_sof && !tx_eof, "R2 idle markers", 64'({tx_sof, tx_eof}), 64'(0));
      end
      if (tx_sof) sof_count++;
    end
  end

  task automatic send(input logic [15:0] op, input logic [47:0] sha,
                      input logic [31:0] spa, input logic [31:0] tpa);
    arp_valid = 1'b1; arp_opcode = op; arp_sha = sha; arp_spa = spa; arp_tpa = tpa;
    @(negedge clk);
    arp_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; arp_valid = 1'b0; arp_opcode = '0;
    arp_sha = '0; arp_spa = '0; arp_tpa = '0;
    cfg_mac = 48'h02_11_22_33_44_55;
    cfg_ip  = 32'hC0A8_010A;
    repeat (3) @(negedge clk);
    check(!tx_valid && !busy, "R1 reset tx/busy", 64'({tx_valid, busy}), 64'(0));
    check(!tx_sof && !tx_eof && !rsp_seen, "R1 reset markers", 64'({tx_sof, tx_eof, rsp_seen}), 64'(0));
    check(peer_mac == '0 && peer_ip == '0, "R1 reset peer", 64'(peer_ip), 64'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!busy && peer_mac == '0, "R1 after release", 64'(busy), 64'(0));

    // R2 matching request
    send(16'd1, 48'hA0A1_A2A3_A4A5, 32'h0A00_0001, 32'hC0A8_010A);
    check(tx_sof == 1'b1, "R2 frame start", 64'(tx_sof), 64'(1));
    check(peer_mac == 48'hA0A1_A2A3_A4A5, "R7 peer mac A", 64'(peer_mac), 64'hA0A1_A2A3_A4A5);
    wait_idle();

    // R8 foreign target
    send(16'd1, 48'hBADB_ADBA_DBAD, 32'h0A00_0063, 32'hC0A8_010B);
    repeat (3) @(negedge clk);
    check(!busy && peer_ip == 32'h0A00_0001, "R8 foreign ignored", 64'(peer_ip), 64'h0A00_0001);

    // R9 received reply, then unknown code
    send(16'd2, 48'h0C0C_0C0C_0C0C, 32'h0A00_0005, 32'hC0A8_010A);
    check(rsp_seen == 1'b1 && !busy, "R9 reply noted", 64'(rsp_seen), 64'(1));
    @(negedge clk);
    check(rsp_seen == 1'b0, "R9 pulse one cycle", 64'(rsp_seen), 64'(0));
    send(16'd3, 48'h0D0D_0D0D_0D0D, 32'h0A00_0006, 32'hC0A8_010A);
    check(!busy && !rsp_seen, "R9 unknown code", 64'({busy, rsp_seen}), 64'(0));

    // R10 request during frame, reply during frame
    send(16'd1, 48'hB0B1_B2B3_B4B5, 32'h0A00_0002, 32'hC0A8_010A);
    repeat (8) @(negedge clk);
    send(16'd1, 48'hC0C1_C2C3_C4C5, 32'h0A00_0003, 32'hC0A8_010A);
    send(16'd2, 48'hC0C1_C2C3_C4C5, 32'h0A00_0003, 32'hC0A8_010A);
    check(rsp_seen && busy, "R9 reply while busy", 64'({rsp_seen, busy}), 64'(3));
    check(peer_ip == 32'h0A00_0002, "R10 drop keeps peer", 64'(peer_ip), 64'h0A00_0002);

    // R10 request on last byte, R11 request on first idle cycle
    while (!tx_eof) @(negedge clk);
    send(16'd1, 48'hD0D1_D2D3_D4D5, 32'h0A00_0004, 32'hC0A8_010A);
    check(!busy && peer_ip == 32'h0A00_0002, "R10 last-byte drop", 64'(peer_ip), 64'h0A00_0002);
    send(16'd1, 48'hE0E1_E2E3_E4E5, 32'h0A00_0007, 32'hC0A8_010A);
    check(tx_sof == 1'b1, "R11 back-to-back start", 64'(tx_sof), 64'(1));
    check(peer_ip == 32'h0A00_0007, "R11 peer E", 64'(peer_ip), 64'h0A00_0007);
    wait_idle();

    // new local configuration
    cfg_mac = 48'h02_66_77_88_99_AA;
    cfg_ip  = 32'hAC10_0001;
    @(negedge clk);
    send(16'd1, 48'hF0F1_F2F3_F4F5, 32'hAC10_0009, 32'hC0A8_010A);
    repeat (2) @(negedge clk);
    check(!busy, "R8 old address ignored", 64'(busy), 64'(0));
    send(16'd1, 48'hF0F1_F2F3_F4F5, 32'hAC10_0009, 32'hAC10_0001);
    wait_idle();

    check(sof_count == 4, "R2 frame count", 64'(sof_count), 64'(4));
    check(peer_mac == 48'hF0F1_F2F3_F4F5, "R7 final peer", 64'(peer_mac), 64'hF0F1_F2F3_F4F5);
    finish_run();
  end
endmodule